// File: doc/BRIEF.md
# Recursive Crosswise Significand Multiplier

This block multiplies two unsigned 24-bit significands and returns the exact 48-bit product. It has no sequential multiply loop and no partial-product array at full width. The product is built by recursion. A 3-by-3 leaf cell forms its six product bits one column at a time, passing the carry from each column to the next. Each level above the leaf splits both operands into a high half and a low half and forms four half-size products. It then merges them with three ripple-carry adders, so the sizes run 3, 6, 12 and 24 bits.

At every level the merge works in three steps:
- The two cross products are added, and the carry out of that sum is kept.
- The upper half of the low-by-low product is added to that sum.
- The high-by-high product is added to everything above the low half of the result.

The lower half-width of the low-by-low product goes straight to the bottom of the result. The top level can register the product behind an active-low asynchronous reset. With the register present, the product appears one clock after its operands.

Top module: `xw_mul24`

## Requirements
- R1: The 3-by-3 leaf cell returns a*b exactly (6 bits) for all 64 operand pairs. Column k sums every ai&bj with i+j=k plus the carry from column k-1. Result bit k is the low bit of that sum, and bit 5 is the final carry.
- R2: A 6-by-6 node built from four leaf cells returns the exact 12-bit product for all 4096 operand pairs.
- R3: A 12-by-12 node built from four 6-by-6 nodes returns the exact 24-bit product.
- R4: The top returns the exact unsigned 48-bit product of op_a and op_b.
- R5: Product bits [11:0] equal bits [11:0] of op_a[11:0]*op_b[11:0].
- R6: The carry out of the cross-product sum is carried into the upper-half addition. At each level, the carry of that sum and the carry of the following addition are never both set. The all-ones case 24'hFFFFFF squared gives 48'hFFFFFE000001.
- R7: Each ripple-carry adder returns {carry_out, sum} equal to x + y + carry_in.
- R8: The upper-half addition at every level never carries out of the 2W-bit product.
- R9: With OUT_REG=1, prod is zero while rst_n is low. After reset, prod holds the product of the operands sampled at the previous rising clock edge.
- R10: A zero operand gives a zero product, and an operand of one gives the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | 24 | Unsigned multiplicand |
| op_b | input | 24 | Unsigned multiplier |
| prod | output | 48 | Unsigned product, registered when OUT_REG=1 |

## Verification
The bench targets operands whose cross products both approach their maximum, such as all-ones and half-all-ones patterns. A design that dropped the carry of the cross-product sum would return a product short by 2^36 at the top, or by a smaller power of two at a lower level. Exhaustive sweeps of the 3-by-3 and 6-by-6 levels expose a leaf column that loses a two-bit carry, which shows up only on pairs with several ones. Zero, one and single-bit operands show a misplaced low-half pass-through as shifted or duplicated bits. Back-to-back vectors through the output register show whether the product lags its operands by more or less than one clock.

// File: rtl/xw_mul_pkg.sv
package xw_mul_pkg;

  function automatic logic [2:0] xw_ext3(input logic x);
    return {2'b00, x};
  endfunction

  // Column-by-column 3x3 product; a column may carry up to 2 into the next.
  function automatic logic [5:0] xw_cross3(input logic [2:0] a, input logic [2:0] b);
    logic [5:0] r;
    logic [2:0] col;
    logic [2:0] cy;
    col  = xw_ext3(a[0] & b[0]);
    r[0] = col[0];
    cy   = {1'b0, col[2:1]};
    col  = cy + xw_ext3(a[0] & b[1]) + xw_ext3(a[1] & b[0]);
    r[1] = col[0];
    cy   = {1'b0, col[2:1]};
    col  = cy + xw_ext3(a[0] & b[2]) + xw_ext3(a[2] & b[0]) + xw_ext3(a[1] & b[1]);
    r[2] = col[0];
    cy   = {1'b0, col[2:1]};
    col  = cy + xw_ext3(a[1] & b[2]) + xw_ext3(a[2] & b[1]);
    r[3] = col[0];
    cy   = {1'b0, col[2:1]};
    col  = cy + xw_ext3(a[2] & b[2]);
    r[4] = col[0];
    r[5] = col[1];
    return r;
  endfunction

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

endpackage

// File: rtl/xw_rca.sv
module xw_rca #(
  parameter int W = 24
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import xw_mul_pkg::*;

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]       = fa_sum(x[i], y[i], chain[i]);
    assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
  end

  assign cout = chain[W];

  // R7: ripple chain agrees with arithmetic addition
  always_comb begin
    p_rca_sum_r7: assert ({cout, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}));
  end

endmodule

// File: rtl/xw_cell3.sv
module xw_cell3 (
  input  logic [2:0] a,
  input  logic [2:0] b,
  output logic [5:0] p
);
  import xw_mul_pkg::*;

  assign p = xw_cross3(a, b);

  // R1: leaf cell exact
  always_comb begin
    p_cell_exact_r1: assert (p == ({3'b000, a} * {3'b000, b}));
  end

endmodule

// File: rtl/xw_node.sv
module xw_node #(
  parameter int W = 24
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  localparam int H = W / 2;

  if (W == 3) begin : g_leaf
    xw_cell3 u_cell (.a(a), .b(b), .p(p));
  end else begin : g_split
    logic [W-1:0] ll, lh, hl, hh;
    logic [W-1:0] cross_s, mid_s, up_s;
    logic         cross_c, mid_c, up_c, mid_top;

    xw_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
    xw_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(lh));
    xw_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(hl));
    xw_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(hh));

    xw_rca #(.W(W)) u_cross (.x(lh), .y(hl), .cin(1'b0), .s(cross_s), .cout(cross_c));
    xw_rca #(.W(W)) u_mid (.x(cross_s), .y({{H{1'b0}}, ll[W-1:H]}), .cin(1'b0),
                           .s(mid_s), .cout(mid_c));
    assign mid_top = cross_c | mid_c;
    xw_rca #(.W(W)) u_up (.x(hh), .y({{(H-1){1'b0}}, mid_top, mid_s[W-1:H]}), .cin(1'b0),
                          .s(up_s), .cout(up_c));

    assign p = {up_s, mid_s[H-1:0], ll[H-1:0]};

    always_comb begin
      // R6: the two carries feeding the upper half never coincide
      p_midcarry_single_r6: assert (!(cross_c && mid_c));
      // R8: upper addition stays inside 2W bits
      p_upper_nocarry_r8: assert (!up_c);
    end
  end

  // R2 / R3: node exact at every level
  always_comb begin
    p_node_exact_r2: assert (p == ({{W{1'b0}}, a} * {{W{1'b0}}, b}));
  end

endmodule

// File: rtl/xw_mul24.sv
module xw_mul24 #(
  parameter int W       = 24,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);

  localparam int H = W / 2;

  logic [2*W-1:0] prod_c;
  logic [H-1:0]   low_pass;

  xw_node #(.W(W)) u_core (.a(op_a), .b(op_b), .p(prod_c));

  assign low_pass = prod_c[H-1:0];

  // R5: low bits come straight from the low-by-low product
  always_comb begin
    p_low_pass_r5: assert (low_pass == H'({{H{1'b0}}, op_a[H-1:0]} * {{H{1'b0}}, op_b[H-1:0]}));
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else        prod <= prod_c;
    end

    // R9: one-cycle latency after reset
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> prod == ({{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)}));
    // R4: registered result exact
    p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(op_a) && $stable(op_b) && $past(rst_n) |=> prod == ({{W{1'b0}}, $past(op_a)} * {{W{1'b0}}, $past(op_b)}));
  end else begin : g_comb
    assign prod = prod_c;
  end

endmodule

// File: tb/xw_mul24_test.sv
module xw_mul24_test;

  typedef struct {
    logic [47:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] op_a = '0, op_b = '0;
  logic [47:0] prod;

  logic [2:0]  a3 = '0, b3 = '0;
  logic [5:0]  p3;
  logic [5:0]  a6 = '0, b6 = '0;
  logic [11:0] p6;
  logic [11:0] a12 = '0, b12 = '0;
  logic [23:0] p12;
  logic [7:0]  rx = '0, ry = '0, rs;
  logic        rc = 1'b0, rco;

  int nvec = 0;
  int nfail = 0;
  int cycles = 0;
  bit driving = 1'b0;
  item_t sb[$];

  always #10 clk = ~clk;

  xw_mul24 uut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod));
  xw_node #(.W(3))  n3  (.a(a3),  .b(b3),  .p(p3));
  xw_node #(.W(6))  n6  (.a(a6),  .b(b6),  .p(p6));
  xw_node #(.W(12)) n12 (.a(a12), .b(b12), .p(p12));
  xw_rca  #(.W(8))  r8  (.x(rx), .y(ry), .cin(rc), .s(rs), .cout(rco));

  // shift-and-add reference
  function automatic logic [47:0] ref_mul(input logic [23:0] a, input logic [23:0] b);
    logic [47:0] acc = '0;
    for (int i = 0; i < 24; i++)
      if (b[i]) acc = acc + ({24'b0, a} << i);
    return acc;
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [23:0] a, input logic [23:0] b, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a;
    op_b = b;
    it.exp = ref_mul(a, b);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: result of a vector driven at a negedge is visible after the next posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (driving && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, prod, it.exp);
        check("R5 low pass", {36'b0, prod[11:0]}, {36'b0, it.exp[11:0]});
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nfail++;
        nvec++;
        $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
      end
    end
  end

  initial begin
    // R1 exhaustive leaf
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        a3 = 3'(i); b3 = 3'(j); #1;
        check("R1 leaf", {42'b0, p3}, ref_mul({21'b0, a3}, {21'b0, b3}));
      end
    // R2 exhaustive 6x6
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++) begin
        a6 = 6'(i); b6 = 6'(j); #1;
        check("R2 6x6", {36'b0, p6}, ref_mul({18'b0, a6}, {18'b0, b6}));
      end
    // R3 12x12 corners and random
    a12 = 12'hFFF; b12 = 12'hFFF; #1;
    check("R3 12x12 max", {24'b0, p12}, ref_mul({12'b0, a12}, {12'b0, b12}));
    for (int k = 0; k < 400; k++) begin
      a12 = 12'($urandom); b12 = 12'($urandom); #1;
      check("R3 12x12", {24'b0, p12}, ref_mul({12'b0, a12}, {12'b0, b12}));
    end
    // R7 adder
    for (int k = 0; k < 200; k++) begin
      rx = 8'($urandom); ry = 8'($urandom); rc = 1'($urandom); #1;
      check("R7 rca", {39'b0, rco, rs}, 48'({40'b0, rx} + {40'b0, ry} + {47'b0, rc}));
    end
    rx = 8'hFF; ry = 8'h00; rc = 1'b1; #1;
    check("R7 rca ripple", {39'b0, rco, rs}, 48'h100);

    // R9 reset value
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", prod, 48'h0);
    @(negedge clk);
    rst_n = 1'b1;
    driving = 1'b1;

    drive(24'hFFFFFF, 24'hFFFFFF, "R6 R8 all ones");
    drive(24'h000FFF, 24'hFFF000, "R6 cross");
    drive(24'hFFF000, 24'h000FFF, "R6 cross swap");
    drive(24'hFFFFFF, 24'h000001, "R10 one");
    drive(24'h000000, 24'hABCDEF, "R10 zero");
    drive(24'h123456, 24'h000000, "R10 zero b");
    drive(24'h000001, 24'h7A5A5A, "R10 one a");
    drive(24'h800000, 24'h800000, "R4 top bits");
    drive(24'h000FFF, 24'h000FFF, "R5 low only");
    drive(24'hFC0FC0, 24'h03F03F, "R6 mixed");
    for (int k = 0; k < 500; k++)
      drive(24'($urandom), 24'($urandom), "R4 R9 random");
    @(negedge clk);
    op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R9 drained", {47'b0, 1'(sb.size() != 0)}, 48'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule